// File: doc/BRIEF.md
# SCL Ratio Clock Generator

This block produces the serial clock for a two-wire bus master. A prescaler divides the reference clock into slots of `div_val + 1` reference cycles. Each SCL period is a low phase followed by a high phase, and the selected ratio sets how many slots each phase lasts. The block pulls the line low through an open-drain enable and never drives it high. It also gives the bit engine two one-cycle strobes. The first falls in the middle of the low phase, where SDA may change. The second falls in the middle of the high phase, where SDA is sampled.

The state machine has three states. ST_IDLE is entered from reset and whenever `en` is low; in it the line is released. ST_LOW holds the line low. ST_HIGH releases the line and counts its slots only while the sampled line `scl_in` reads high. The transitions are:

- IDLE→LOW on `en`.
- LOW→HIGH when the last low slot ends.
- HIGH→LOW when the last high slot ends.
- LOW→IDLE and HIGH→IDLE when `en` drops.

Ratio and divisor are copied into shadow registers on every entry to ST_LOW. Software may therefore rewrite them at any time without producing a runt pulse. The shadows reset to ratio 0 with a standard-rate divisor.

Top module: `scl_ratio_gen`

## Requirements
- R1: While reset is asserted or `en` is low, `scl_drive_low`, `mid_low_stb` and `mid_high_stb` are all 0. Dropping `en` releases the line in that same cycle, and the block returns to idle at the next edge.
- R2: From idle, the first clock edge that sees `en` high starts a low phase.
- R3: `ratio_sel` = 0 gives 4 low slots and 4 high slots. The unused code 3 behaves the same as 0.
- R4: `ratio_sel` = 1 gives 6 low slots and 3 high slots.
- R5: `ratio_sel` = 2 gives 11 low slots and 3 high slots.
- R6: Each slot lasts `div_val + 1` reference cycles. An unstretched SCL period is therefore (low slots + high slots) × (`div_val` + 1) cycles.
- R7: `mid_low_stb` pulses exactly once per low phase. It comes floor(low slots / 2) × (`div_val` + 1) cycles after the phase's first cycle.
- R8: `mid_high_stb` pulses exactly once per high phase. It comes after floor(high slots / 2) × (`div_val` + 1) cycles during which `scl_in` was high.
- R9: During a high phase, time is counted only while `scl_in` is high. A device holding the line low lengthens the released period and does not shorten the high time.
- R10: A new `ratio_sel` or `div_val` is taken only when a low phase begins. A phase already running completes with its old settings.
- R11: Enabling again after a disable starts a full-length low phase from slot zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable |
| ratio_sel | input | 2 | Low:high ratio code (0 = 4:4, 1 = 6:3, 2 = 11:3, 3 = 4:4) |
| div_val | input | DIV_W | Slot length minus one, in reference cycles |
| scl_in | input | 1 | Synchronised level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| mid_low_stb | output | 1 | One-cycle pulse mid low phase (SDA change point) |
| mid_high_stb | output | 1 | One-cycle pulse mid high phase (SDA sample point) |

## Verification
The bench measures phase lengths and strobe offsets for every ratio code, with divisors from 0 to 3. A swapped ratio table or an off-by-one prescaler would show up as a wrong phase length or period. It rewrites the settings in the middle of a low phase and expects that period to keep its old shape. A design that takes the new values at once would produce a runt phase. It holds the line low for twenty cycles after release and expects a full high phase and a late sample strobe. A generator that counts without looking at the line would cut the high phase short or strobe while the line is still low. It also disables the block in the middle of the low phase and expects the line released in that same cycle, followed by a fresh full low phase on re-enable.

// File: rtl/scl_ratio_pkg.sv
package scl_ratio_pkg;

    localparam int SLOT_W = 4;

    localparam logic [1:0] RATIO_EVEN     = 2'd0;
    localparam logic [1:0] RATIO_FAST     = 2'd1;
    localparam logic [1:0] RATIO_FASTPLUS = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } gen_state_e;

endpackage

// File: rtl/scl_ratio_decode.sv
module scl_ratio_decode
    import scl_ratio_pkg::*;
(
    input  logic [1:0]        ratio,
    output logic [SLOT_W-1:0] low_slots,
    output logic [SLOT_W-1:0] high_slots
);

    always_comb begin
        unique case (ratio)
            RATIO_FAST: begin
                low_slots  = SLOT_W'(6);
                high_slots = SLOT_W'(3);
            end
            RATIO_FASTPLUS: begin
                low_slots  = SLOT_W'(11);
                high_slots = SLOT_W'(3);
            end
            default: begin
                low_slots  = SLOT_W'(4);
                high_slots = SLOT_W'(4);
            end
        endcase
    end

endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         at_zero,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    assign at_zero = (cnt_q == '0);
    assign tick    = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/scl_ratio_gen.sv
module scl_ratio_gen
    import scl_ratio_pkg::*;
#(
    parameter int               DIV_W     = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(59)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       ratio_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             mid_low_stb,
    output logic             mid_high_stb
);

    gen_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [1:0]        rsel_q;
    logic [DIV_W-1:0]  div_q;
    logic              load_shadow;

    logic [SLOT_W-1:0] low_slots, high_slots;
    logic              pre_zero, pre_tick, pre_clr, pre_run;
    logic              last_low, last_high;

    scl_ratio_decode u_decode (
        .ratio      (rsel_q),
        .low_slots  (low_slots),
        .high_slots (high_slots)
    );

    assign pre_clr = (state_q == ST_IDLE);
    assign pre_run = (state_q == ST_LOW) || ((state_q == ST_HIGH) && scl_in);

    scl_prescale #(.W(DIV_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pre_clr),
        .run     (pre_run),
        .limit   (div_q),
        .at_zero (pre_zero),
        .tick    (pre_tick)
    );

    assign last_low  = (slot_q == low_slots  - SLOT_W'(1));
    assign last_high = (slot_q == high_slots - SLOT_W'(1));

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        slot_d      = slot_q;
        load_shadow = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_d     = ST_LOW;
                    slot_d      = '0;
                    load_shadow = 1'b1;
                end
            end
            ST_LOW: begin
                if (!en) begin
                    state_d = ST_IDLE;
                    slot_d  = '0;
                end else if (pre_tick) begin
                    if (last_low) begin
                        state_d = ST_HIGH;
                        slot_d  = '0;
                    end else begin
                        slot_d = slot_q + SLOT_W'(1);
                    end
                end
            end
            ST_HIGH: begin
                if (!en) begin
                    state_d = ST_IDLE;
                    slot_d  = '0;
                end else if (pre_tick) begin
                    if (last_high) begin
                        state_d     = ST_LOW;
                        slot_d      = '0;
                        load_shadow = 1'b1;
                    end else begin
                        slot_d = slot_q + SLOT_W'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                slot_d  = '0;
            end
        endcase
    end

    // State register and shadow settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            rsel_q  <= RATIO_EVEN;
            div_q   <= DIV_RESET;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            if (load_shadow) begin
                rsel_q <= ratio_sel;
                div_q  <= div_val;
            end
        end
    end

    // Outputs
    always_comb begin
        scl_drive_low = en && (state_q == ST_LOW);
        mid_low_stb   = en && (state_q == ST_LOW) && pre_zero
                        && (slot_q == (low_slots >> 1));
        mid_high_stb  = en && (state_q == ST_HIGH) && scl_in && pre_zero
                        && (slot_q == (high_slots >> 1));
    end

endmodule

// File: rtl/scl_ratio_gen_chk.sv
module scl_ratio_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_drive_low,
    input logic mid_low_stb,
    input logic mid_high_stb
);

    logic [7:0] low_run;
    logic [7:0] hi_run;
    logic       seen_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= '0;
            hi_run   <= '0;
            seen_low <= 1'b0;
        end else begin
            if (scl_drive_low) low_run <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
            else               low_run <= '0;

            if (!en || scl_drive_low)   hi_run <= '0;
            else if (scl_in)            hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 8'd1;

            if (!en)                seen_low <= 1'b0;
            else if (scl_drive_low) seen_low <= 1'b1;
        end
    end

    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_drive_low && !mid_low_stb && !mid_high_stb)); // R1

    AST_MIDLOW_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mid_low_stb |-> scl_drive_low); // R7

    AST_MIDHIGH_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mid_high_stb |-> (!scl_drive_low && scl_in)); // R8

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mid_low_stb && mid_high_stb)); // R7

    AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_drive_low) && en) |-> (low_run >= 8'd4)); // R3

    AST_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_drive_low) && seen_low) |-> (hi_run >= 8'd3)); // R9

endmodule

bind scl_ratio_gen scl_ratio_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .mid_low_stb   (mid_low_stb),
    .mid_high_stb  (mid_high_stb)
);

// File: tb/tb_scl_ratio_gen.sv
module tb_scl_ratio_gen;

    localparam int CLK_P = 10;
    localparam int DIV_W = 8;

    // ratio, div, low len, high len, mid-low offset, mid-high offset
    localparam int NV = 7;
    localparam int VEC [0:NV-1][0:5] = '{
        '{0, 1,  8,  8,  4, 4},
        '{1, 2, 18,  9,  9, 3},
        '{2, 0, 11,  3,  5, 1},
        '{3, 1,  8,  8,  4, 4},
        '{0, 0,  4,  4,  2, 2},
        '{2, 3, 44, 12, 20, 4},
        '{1, 0,  6,  3,  3, 1}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic [1:0]       ratio_sel;
    logic [DIV_W-1:0] div_val;
    logic             stretch;
    logic             scl_in;
    logic             scl_drive_low;
    logic             mid_low_stb;
    logic             mid_high_stb;

    int total = 0;
    int bad   = 0;

    assign scl_in = !scl_drive_low && !stretch;

    always #(CLK_P/2) clk = ~clk;

    scl_ratio_gen #(.DIV_W(DIV_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .ratio_sel     (ratio_sel),
        .div_val       (div_val),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .mid_low_stb   (mid_low_stb),
        .mid_high_stb  (mid_high_stb)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic prev;
        do begin
            prev = scl_drive_low;
            @(negedge clk);
        end while (!(scl_drive_low && !prev));
    endtask

    // Called on the sample where the line was just pulled low.
    task automatic measure(output int lo, output int hi, output int ml_off,
                           output int mh_off, output int ml_n, output int mh_n);
        int idx;
        idx = 0; ml_off = -1; mh_off = -1; ml_n = 0; mh_n = 0;
        while (scl_drive_low) begin
            if (mid_low_stb) begin ml_off = idx; ml_n++; end
            idx++;
            @(negedge clk);
        end
        lo = idx;
        idx = 0;
        while (!scl_drive_low) begin
            if (mid_high_stb) begin mh_off = idx; mh_n++; end
            idx++;
            @(negedge clk);
        end
        hi = idx;
    endtask

    initial begin
        #(CLK_P * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lo, hi, mlo, mho, mln, mhn, idx;
        string tg;
        rst_n = 1'b0; en = 1'b0; ratio_sel = 2'd0; div_val = 8'd1; stretch = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "drive in reset", int'(scl_drive_low), 0);
        chk("R1", "strobes in reset", int'(mid_low_stb | mid_high_stb), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "drive while disabled", int'(scl_drive_low), 0);

        // R2: enable latency
        en = 1'b1;
        #1 chk("R2", "drive before edge", int'(scl_drive_low), 0);
        @(negedge clk);
        chk("R2", "drive after first edge", int'(scl_drive_low), 1);
        measure(lo, hi, mlo, mho, mln, mhn);
        chk("R2", "first low length", lo, 8);

        // Vector walk over ratios and divisors
        for (int i = 0; i < NV; i++) begin
            ratio_sel = 2'(VEC[i][0]);
            div_val   = DIV_W'(VEC[i][1]);
            wait_rise();
            measure(lo, hi, mlo, mho, mln, mhn);
            tg = (VEC[i][0] == 1) ? "R4" : (VEC[i][0] == 2) ? "R5" : "R3";
            chk(tg, "low length", lo, VEC[i][2]);
            chk(tg, "high length", hi, VEC[i][3]);
            chk("R6", "period", lo + hi, VEC[i][2] + VEC[i][3]);
            chk("R7", "mid-low offset", mlo, VEC[i][4]);
            chk("R7", "mid-low count", mln, 1);
            chk("R8", "mid-high offset", mho, VEC[i][5]);
            chk("R8", "mid-high count", mhn, 1);
        end

        // R10: change settings at the start of a low phase
        ratio_sel = 2'd0; div_val = 8'd1;
        wait_rise();
        measure(lo, hi, mlo, mho, mln, mhn);
        ratio_sel = 2'd2; div_val = 8'd0;
        measure(lo, hi, mlo, mho, mln, mhn);
        chk("R10", "running low kept", lo, 8);
        chk("R10", "running high kept", hi, 8);
        measure(lo, hi, mlo, mho, mln, mhn);
        chk("R10", "next low new", lo, 11);
        chk("R10", "next high new", hi, 3);

        // R9: slave stretches the clock
        ratio_sel = 2'd0; div_val = 8'd1;
        wait_rise();
        stretch = 1'b1;
        while (scl_drive_low) @(negedge clk);
        mhn = 0;
        for (int k = 0; k < 20; k++) begin
            if (mid_high_stb || scl_drive_low) mhn++;
            @(negedge clk);
        end
        chk("R9", "activity while stretched", mhn, 0);
        stretch = 1'b0;
        #1;
        idx = 0; mho = -1;
        while (!scl_drive_low) begin
            if (mid_high_stb) mho = idx;
            idx++;
            @(negedge clk);
        end
        chk("R9", "high after stretch", idx, 8);
        chk("R8", "mid-high after stretch", mho, 4);

        // R1 / R11: disable mid-low, then re-enable
        measure(lo, hi, mlo, mho, mln, mhn);
        wait_rise();
        repeat (3) @(negedge clk);
        en = 1'b0;
        #1 chk("R1", "release same cycle", int'(scl_drive_low), 0);
        mln = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (scl_drive_low || mid_low_stb || mid_high_stb) mln++;
        end
        chk("R1", "outputs while disabled", mln, 0);
        en = 1'b1;
        #1 chk("R11", "idle before edge", int'(scl_drive_low), 0);
        @(negedge clk);
        chk("R11", "low restarts", int'(scl_drive_low), 1);
        measure(lo, hi, mlo, mho, mln, mhn);
        chk("R11", "full low after re-enable", lo, 8);
        chk("R11", "full high after re-enable", hi, 8);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule